// File: doc/BRIEF.md
# Clock Lock Detector with Feedback-Loss Watchdog

This block decides whether a clock loop is locked by watching the rising edges of a reference clock and a feedback clock. Both arrive asynchronously and are sampled by a faster detector clock. Each feedback edge is judged either clean or in error. A judgment is clean when a reference edge falls within a tolerance window of plus or minus `WIN` detector ticks around the feedback edge. Runs of consecutive judgments are counted, and the lock flag is driven from those runs with hysteresis. A short run of errors drops the flag. A much longer run of clean judgments is needed to raise it again.

A feedback clock that simply stops produces no judgments at all. To cover that case, a watchdog counts divided-down reference edges since the last feedback edge. When the count runs out, the watchdog clears the lock flag. The watchdog relies on the reference clock toggling. Without a reference clock, the flag carries no meaning.

The block has two debug outputs. One shows the current run length of clean judgments and the other shows the current run length of error judgments.

Top module: `lock_watch`

## Requirements
- R1: While reset is asserted and right after it is released, `lock_o` is 0, `ok_run_o` is 0 and `err_run_o` is 0.
- R2: A feedback edge is judged clean when a reference edge lies no more than `WIN` detector ticks (default 3) before or after it. It is judged an error when the distance is `WIN+1` or more, whether the feedback edge is early or late. An early feedback edge is resolved when the reference edge arrives, or after `WIN` ticks without one.
- R3: While unlocked, `lock_o` rises on the `OK_NEED`-th (default 32) consecutive clean judgment and not before it.
- R4: While locked, `lock_o` falls on the `ERR_LIMIT`-th (default 4) consecutive error judgment. Fewer consecutive errors leave it high.
- R5: A clean judgment resets `err_run_o` to 0 and an error judgment resets `ok_run_o` to 0. `ok_run_o` saturates at `OK_NEED` and `err_run_o` saturates at `ERR_LIMIT`.
- R6: A watchdog step is produced every `REF_DIV` (default 4) reference edges. When `WD_LIMIT` (default 8) steps pass with no feedback edge, `lock_o`, `ok_run_o` and `err_run_o` are cleared. This takes priority over a judgment made in the same tick.
- R7: Every feedback edge restarts the watchdog. A feedback clock that keeps running therefore never trips the watchdog, however many reference edges go by.
- R8: Each input passes through two synchronizer stages and one edge-detect stage. A rising input that is sampled at detector edge k therefore affects the outputs from detector edge k+2 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| det_clk | input | 1 | Detector sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock, asynchronous to det_clk |
| fb_clk_i | input | 1 | Feedback clock, asynchronous to det_clk |
| lock_o | output | 1 | 1 = locked, 0 = acquiring lock |
| err_run_o | output | $clog2(ERR_LIMIT+1) | Current count of consecutive error judgments |
| ok_run_o | output | $clog2(OK_NEED+1) | Current count of consecutive clean judgments |

## Verification
Two situations are hard to bring about from the ports. The first is the exact edge of the tolerance window in both directions, because an early feedback edge is only resolved later, by the reference edge or by a timeout. The stimulus therefore builds each reference period by hand, with the feedback edge placed 3 or 4 ticks late, or the reference edge 3 or 4 ticks late. The second is the watchdog expiring, which needs tens of reference edges with no feedback at all. The bench first gains lock, then stops the feedback clock. It checks that the flag is still high after exactly seven divided steps and that it drops once the eighth step has passed.

// File: rtl/lkw_pkg.sv
package lkw_pkg;
    typedef struct packed {
        logic valid;
        logic err;
    } verdict_t;
endpackage

// File: rtl/lkw_edge.sv
module lkw_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], sig_i};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sh[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/lkw_phase.sv
module lkw_phase
    import lkw_pkg::*;
#(
    parameter int WIN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_rise_i,
    input  logic     fb_rise_i,
    output verdict_t verdict_o
);
    localparam int AW = $clog2(WIN + 2);
    localparam logic [AW-1:0] AGE_SAT = AW'(WIN + 1);
    localparam logic [AW-1:0] WIN_C   = AW'(WIN);
    localparam logic [AW-1:0] ONE_C   = AW'(1);

    typedef struct packed {
        logic [AW-1:0] age;
        logic          pend;
        logic [AW-1:0] pcnt;
    } st_t;

    st_t           s_q, s_d;
    verdict_t      v;
    logic [AW-1:0] age_now;

    always_comb begin
        s_d     = s_q;
        v       = '0;
        age_now = ref_rise_i ? '0 : s_q.age;
        if (s_q.pend) begin
            if (ref_rise_i) begin
                v.valid  = 1'b1;
                s_d.pend = 1'b0;
            end else if (fb_rise_i) begin
                v.valid  = 1'b1;
                v.err    = 1'b1;
                s_d.pcnt = ONE_C;
            end else if (s_q.pcnt >= WIN_C) begin
                v.valid  = 1'b1;
                v.err    = 1'b1;
                s_d.pend = 1'b0;
            end else begin
                s_d.pcnt = s_q.pcnt + ONE_C;
            end
        end else if (fb_rise_i) begin
            if (age_now <= WIN_C) begin
                v.valid = 1'b1;
            end else begin
                s_d.pend = 1'b1;
                s_d.pcnt = ONE_C;
            end
        end
        if (ref_rise_i)             s_d.age = ONE_C;
        else if (s_q.age < AGE_SAT) s_d.age = s_q.age + ONE_C;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.age  <= AGE_SAT;
            s_q.pend <= 1'b0;
            s_q.pcnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign verdict_o = v;
endmodule

// File: rtl/lkw_watchdog.sv
module lkw_watchdog #(
    parameter int REF_DIV  = 4,
    parameter int WD_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise_i,
    input  logic fb_rise_i,
    output logic expire_o
);
    localparam int DW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam int WW = $clog2(WD_LIMIT + 1);
    localparam logic [DW-1:0] DIV_TOP = DW'(REF_DIV - 1);
    localparam logic [WW-1:0] WD_TOP  = WW'(WD_LIMIT);
    localparam logic [WW-1:0] WD_M1   = WW'(WD_LIMIT - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [WW-1:0] wd;
    } st_t;

    st_t  s_q, s_d;
    logic step;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        step     = ref_rise_i && (s_q.div == DIV_TOP);
        if (ref_rise_i) s_d.div = step ? '0 : s_q.div + DW'(1);
        if (fb_rise_i) begin
            s_d.wd = '0;
        end else if (step && (s_q.wd != WD_TOP)) begin
            s_d.wd   = s_q.wd + WW'(1);
            expire_o = (s_q.wd == WD_M1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lkw_hyst.sv
module lkw_hyst
    import lkw_pkg::*;
#(
    parameter int ERR_LIMIT = 4,
    parameter int OK_NEED   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  verdict_t                     verdict_i,
    input  logic                         expire_i,
    output logic                         lock_o,
    output logic [$clog2(ERR_LIMIT+1)-1:0] err_run_o,
    output logic [$clog2(OK_NEED+1)-1:0]   ok_run_o
);
    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam int OW = $clog2(OK_NEED + 1);
    localparam logic [EW-1:0] ERR_C  = EW'(ERR_LIMIT);
    localparam logic [EW-1:0] ERR_M1 = EW'(ERR_LIMIT - 1);
    localparam logic [OW-1:0] OK_C   = OW'(OK_NEED);
    localparam logic [OW-1:0] OK_M1  = OW'(OK_NEED - 1);

    typedef struct packed {
        logic          lock;
        logic [EW-1:0] err;
        logic [OW-1:0] ok;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (expire_i) begin
            s_d = '0;
        end else if (verdict_i.valid) begin
            if (!verdict_i.err) begin
                s_d.err = '0;
                if (s_q.ok != OK_C) s_d.ok = s_q.ok + OW'(1);
                if (s_q.ok >= OK_M1) s_d.lock = 1'b1;
            end else begin
                s_d.ok = '0;
                if (s_q.err != ERR_C) s_d.err = s_q.err + EW'(1);
                if (s_q.err >= ERR_M1) s_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lock_o    = s_q.lock;
    assign err_run_o = s_q.err;
    assign ok_run_o  = s_q.ok;
endmodule

// File: rtl/lock_watch.sv
module lock_watch
    import lkw_pkg::*;
#(
    parameter int WIN       = 3,
    parameter int REF_DIV   = 4,
    parameter int WD_LIMIT  = 8,
    parameter int ERR_LIMIT = 4,
    parameter int OK_NEED   = 32,
    parameter int SYNC      = 2
) (
    input  logic                           det_clk,
    input  logic                           rst_n,
    input  logic                           ref_clk_i,
    input  logic                           fb_clk_i,
    output logic                           lock_o,
    output logic [$clog2(ERR_LIMIT+1)-1:0] err_run_o,
    output logic [$clog2(OK_NEED+1)-1:0]   ok_run_o
);
    logic [1:0] raw_in;
    logic [1:0] rise;
    verdict_t   verdict;
    logic       wd_expire;

    assign raw_in = {fb_clk_i, ref_clk_i};

    for (genvar g = 0; g < 2; g++) begin : g_in
        lkw_edge #(.STAGES(SYNC)) u_edge (
            .clk    (det_clk),
            .rst_n  (rst_n),
            .sig_i  (raw_in[g]),
            .rise_o (rise[g])
        );
    end

    lkw_phase #(.WIN(WIN)) u_phase (
        .clk        (det_clk),
        .rst_n      (rst_n),
        .ref_rise_i (rise[0]),
        .fb_rise_i  (rise[1]),
        .verdict_o  (verdict)
    );

    lkw_watchdog #(.REF_DIV(REF_DIV), .WD_LIMIT(WD_LIMIT)) u_wd (
        .clk        (det_clk),
        .rst_n      (rst_n),
        .ref_rise_i (rise[0]),
        .fb_rise_i  (rise[1]),
        .expire_o   (wd_expire)
    );

    lkw_hyst #(.ERR_LIMIT(ERR_LIMIT), .OK_NEED(OK_NEED)) u_hyst (
        .clk       (det_clk),
        .rst_n     (rst_n),
        .verdict_i (verdict),
        .expire_i  (wd_expire),
        .lock_o    (lock_o),
        .err_run_o (err_run_o),
        .ok_run_o  (ok_run_o)
    );
endmodule

// File: rtl/lock_watch_chk.sv
module lock_watch_chk #(
    parameter int ERR_LIMIT = 4,
    parameter int OK_NEED   = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           lock,
    input logic [$clog2(ERR_LIMIT+1)-1:0] err_run,
    input logic [$clog2(OK_NEED+1)-1:0]   ok_run,
    input logic                           expire
);
    // R1: the first cycle out of reset starts unlocked with empty runs
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lock && ok_run == 0 && err_run == 0));

    // R3: lock only rises with a full clean run recorded
    p_rise_full_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> (ok_run == OK_NEED && err_run == 0));

    // R4: lock only falls on a full error run or on a watchdog clear
    p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> (err_run == ERR_LIMIT || (ok_run == 0 && err_run == 0)));

    // R4: a locked state never holds a complete error run
    p_locked_errs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (err_run < ERR_LIMIT));

    // R5: the two runs exclude each other and stay within limits
    p_runs_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_run != 0 && err_run != 0));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_run <= OK_NEED && err_run <= ERR_LIMIT));

    // R6: a watchdog expiry leaves the detector unlocked and cleared
    p_wd_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!lock && ok_run == 0 && err_run == 0));
endmodule

bind lock_watch lock_watch_chk #(.ERR_LIMIT(ERR_LIMIT), .OK_NEED(OK_NEED)) u_chk (
    .clk     (det_clk),
    .rst_n   (rst_n),
    .lock    (lock_o),
    .err_run (err_run_o),
    .ok_run  (ok_run_o),
    .expire  (wd_expire)
);

// File: tb/lock_watch_test.sv
`timescale 1ns/1ps
module lock_watch_test;
    localparam int WIN = 3, REF_DIV = 4, WD_LIMIT = 8, ERR_LIMIT = 4, OK_NEED = 32;
    localparam int PER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic lock_o;
    logic [$clog2(ERR_LIMIT+1)-1:0] err_run_o;
    logic [$clog2(OK_NEED+1)-1:0]   ok_run_o;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lock_watch uut (
        .det_clk   (clk),
        .rst_n     (rst_n),
        .ref_clk_i (ref_in),
        .fb_clk_i  (fb_in),
        .lock_o    (lock_o),
        .err_run_o (err_run_o),
        .ok_run_o  (ok_run_o)
    );

    // behavioural model, updated on each detector edge
    int rp1, rp2, rp3, fp1, fp2, fp3;
    int m_age, m_pend, m_pcnt, m_div, m_wd, m_lock, m_ok, m_err;

    always @(posedge clk) begin
        int re, fe, age_now, vv, ve, step, ex;
        if (!rst_n) begin
            rp1 = 0; rp2 = 0; rp3 = 0; fp1 = 0; fp2 = 0; fp3 = 0;
            m_age = WIN + 1; m_pend = 0; m_pcnt = 0; m_div = 0; m_wd = 0;
            m_lock = 0; m_ok = 0; m_err = 0;
        end else begin
            re = (rp2 == 1 && rp3 == 0) ? 1 : 0;
            fe = (fp2 == 1 && fp3 == 0) ? 1 : 0;
            rp3 = rp2; rp2 = rp1; rp1 = int'(ref_in);
            fp3 = fp2; fp2 = fp1; fp1 = int'(fb_in);
            age_now = re ? 0 : m_age;
            vv = 0; ve = 0;
            if (m_pend != 0) begin
                if (re != 0) begin vv = 1; m_pend = 0; end
                else if (fe != 0) begin vv = 1; ve = 1; m_pcnt = 1; end
                else if (m_pcnt >= WIN) begin vv = 1; ve = 1; m_pend = 0; end
                else m_pcnt++;
            end else if (fe != 0) begin
                if (age_now <= WIN) vv = 1;
                else begin m_pend = 1; m_pcnt = 1; end
            end
            if (re != 0) m_age = 1;
            else if (m_age < WIN + 1) m_age++;
            step = 0;
            if (re != 0) begin
                m_div++;
                if (m_div == REF_DIV) begin step = 1; m_div = 0; end
            end
            ex = 0;
            if (fe != 0) m_wd = 0;
            else if (step != 0 && m_wd < WD_LIMIT) begin
                m_wd++;
                if (m_wd == WD_LIMIT) ex = 1;
            end
            if (ex != 0) begin
                m_lock = 0; m_ok = 0; m_err = 0;
            end else if (vv != 0) begin
                if (ve == 0) begin
                    m_err = 0;
                    if (m_ok < OK_NEED) m_ok++;
                    if (m_ok >= OK_NEED) m_lock = 1;
                end else begin
                    m_ok = 0;
                    if (m_err < ERR_LIMIT) m_err++;
                    if (m_err >= ERR_LIMIT) m_lock = 0;
                end
            end
        end
    end

    task automatic check(input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // R8: per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(int'(lock_o), m_lock, "R8 per-cycle lock_o");
            check(int'(ok_run_o), m_ok, "R8 per-cycle ok_run_o");
            check(int'(err_run_o), m_err, "R8 per-cycle err_run_o");
        end
    end

    task automatic periods(input int count, input int fb_off, input int ref_off, input bit fb_on);
        for (int p = 0; p < count; p++) begin
            for (int tk = 0; tk < PER; tk++) begin
                @(negedge clk);
                ref_in = (tk >= ref_off && tk < ref_off + 8);
                fb_in  = fb_on && (tk >= fb_off && tk < fb_off + 8);
            end
        end
    endtask

    task automatic expect3(input int lk, input int ok, input int er, input string req);
        check(int'(lock_o), lk, {req, " lock_o"});
        check(int'(ok_run_o), ok, {req, " ok_run_o"});
        check(int'(err_run_o), er, {req, " err_run_o"});
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect3(0, 0, 0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect3(0, 0, 0, "R1 after reset");

        periods(31, 0, 0, 1);
        expect3(0, 31, 0, "R3 31 clean no lock");
        periods(1, 0, 0, 1);
        expect3(1, 32, 0, "R3 32nd clean locks");
        periods(10, 0, 0, 1);
        expect3(1, 32, 0, "R5 ok saturates / R7 running fb holds lock");

        periods(3, 4, 0, 1);
        expect3(1, 0, 3, "R4 three errors keep lock / R2 late by 4 errs");
        periods(1, 3, 0, 1);
        expect3(1, 1, 0, "R2 late by 3 clean / R5 clean clears errs");
        periods(1, 0, 3, 1);
        expect3(1, 2, 0, "R2 early by 3 clean");
        periods(1, 0, 4, 1);
        expect3(1, 0, 1, "R2 early by 4 errs / R5 error clears ok");
        periods(3, 4, 0, 1);
        expect3(0, 0, 4, "R4 fourth error drops lock");
        periods(2, 4, 0, 1);
        expect3(0, 0, 4, "R5 err saturates");

        periods(32, 0, 0, 1);
        expect3(1, 32, 0, "R3 relock after 32 clean");
        periods(28, 0, 0, 0);
        expect3(1, 32, 0, "R6 seven steps without fb keep lock");
        periods(6, 0, 0, 0);
        expect3(0, 0, 0, "R6 watchdog expiry clears lock");
        periods(5, 0, 0, 1);
        expect3(0, 5, 0, "R7 fb resumes counting from zero");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule